// File: doc/BRIEF.md
# AES3 Mono-Mode Sample Router

This block takes audio subframes that an upstream receiver has already decoded and drives a serial audio output port as its master. Each input strobe carries one 24-bit sample, a flag telling whether the sample came from the first (A) or second (B) subframe of its frame, and a frame-start flag. The block assembles A/B pairs into frames, queues them, and shifts them out as a word clock, a bit clock and a serial data line. The serial frame is in the I2S style: 32 bit clocks per channel slot, left channel while the word clock is low, and 24 data bits MSB first starting one bit clock after each word-clock edge.

A mode input picks how each frame reaches the output. In stereo mode one frame fills one word-clock cycle: A goes left and B goes right. In mono mode the output word clock runs at twice the input frame rate. A fills both channels of one word-clock cycle, and B fills both channels of the next one. This lets a double-rate mono signal be carried on a link that runs at the base frame rate. The mode is captured with each frame as it opens, so a change never splits a frame.

The bit clock is derived from a tick input that the system supplies at twice the bit rate. If the queue runs dry the output repeats the last sample pair and raises a sticky underrun flag.

Top module: `aes_mono_router`

## Requirements
- R1: After reset the bit clock output is high, the word clock is held high, serial data is low and the underrun flag is low. The word clock and data stay that way until the first complete frame has been queued.
- R2: The bit clock output inverts on every clock edge that sees `half_tick_i` high and on no other edge. The word clock and serial data change only on edges where the bit clock falls.
- R3: Each word-clock cycle is 64 bit clocks long: 32 with the word clock low (left slot) and 32 with it high (right slot). In each slot, bit positions 1 to 24 after the word-clock edge carry the sample MSB first, and positions 0 and 25 to 31 are zero.
- R4: An A strobe (`sf_is_b_i` = 0) with `sf_frame_start_i` = 1 opens a frame, which a later B strobe (`sf_is_b_i` = 1) completes and queues. An A strobe without frame start, and a B strobe with no open frame, have no effect on the output.
- R5: A frame captured in stereo mode (`mono_mode_i` = 0) produces one word-clock cycle with A in the left slot and B in the right slot.
- R6: A frame captured in mono mode (`mono_mode_i` = 1) produces two word-clock cycles. The first carries A in both slots and the second carries B in both slots.
- R7: The mode of a frame is the value of `mono_mode_i` on its opening A strobe. A change made before the B strobe affects only later frames.
- R8: The queue holds two complete frames. A frame completed while the queue is full is discarded, and the queued frames are output unchanged.
- R9: Once output has started, if no frame is queued when a word-clock cycle begins, the previous sample pair is repeated and `underrun_o` goes high. It stays high until reset. It stays low while frames arrive in time.
- R10: Output starts at the first bit-clock fall after the first frame is queued, beginning with a left slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mono_mode_i | input | 1 | 1 selects mono routing, 0 stereo; sampled on frame-opening strobes |
| sf_valid_i | input | 1 | Subframe strobe, one cycle per subframe |
| sf_is_b_i | input | 1 | 0 for subframe A, 1 for subframe B |
| sf_frame_start_i | input | 1 | Marks the A strobe that begins a frame |
| sf_sample_i | input | 24 | Audio sample of the strobed subframe |
| half_tick_i | input | 1 | Pulse at twice the bit rate; each one inverts the bit clock |
| bclk_o | output | 1 | Serial bit clock; receivers sample on its rising edge |
| wclk_o | output | 1 | Word clock; low for the left slot |
| sdata_o | output | 1 | Serial data, MSB first |
| underrun_o | output | 1 | Sticky flag: a cycle began with the queue empty |

## Verification
A wrong frame-assembly or queue state shows up at the port as a decoded sample pair that differs from the one expected. It appears within one word-clock cycle of the affected frame reaching the head of the queue, or up to three cycles later when a full queue hides it. A broken mono phase shows as one cycle holding A where B belongs, or as a stereo split, on the very next word-clock cycle. A slot counter that is off shifts the word-clock edge or lets nonzero bits into the padding positions, and this is visible within a single slot. An underrun flag that is set wrongly, or that clears, is read directly at the port, both at the end of a fed run and again after starved cycles.

// File: rtl/aes_mr_pkg.sv
package aes_mr_pkg;

    localparam int SMP_W = 24;

    typedef logic [SMP_W-1:0] sample_t;

    // One assembled input frame with the routing mode captured at its start.
    typedef struct packed {
        logic    mono;
        sample_t a;
        sample_t b;
    } frame_t;

    // Level of the serial line at slot position k (0 = the bit at the word-clock edge).
    function automatic logic slot_bit(sample_t w, int unsigned k);
        sample_t t;
        if (k >= 1 && k <= SMP_W) begin
            t = w << (k - 1);
            return t[SMP_W-1];
        end
        return 1'b0;
    endfunction

endpackage

// File: rtl/aes_mr_ingest.sv
module aes_mr_ingest
    import aes_mr_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    mode_i,
    input  logic    valid_i,
    input  logic    is_b_i,
    input  logic    fstart_i,
    input  sample_t sample_i,
    output logic    push_o,
    output frame_t  frame_o
);

    logic    open_q;
    logic    mono_q;
    sample_t a_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            mono_q <= 1'b0;
            a_q    <= '0;
        end else if (valid_i) begin
            if (!is_b_i && fstart_i) begin
                open_q <= 1'b1;
                mono_q <= mode_i;
                a_q    <= sample_i;
            end else if (is_b_i && open_q) begin
                open_q <= 1'b0;
            end
        end
    end

    assign push_o  = valid_i && is_b_i && open_q;
    assign frame_o = '{mono: mono_q, a: a_q, b: sample_i};

    // R4
    closes_frame_chk: assert property (@(posedge clk) disable iff (rst)
        (push_o && !fstart_i) |=> !open_q);

endmodule

// File: rtl/aes_mr_fifo.sv
module aes_mr_fifo
    import aes_mr_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   push_i,
    input  frame_t frame_i,
    input  logic   pop_i,
    output logic   empty_o,
    output frame_t frame_o
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST_A = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_C = CW'(DEPTH);

    frame_t          mem [DEPTH];
    logic [AW-1:0]   wr_q, rd_q;
    logic [CW-1:0]   cnt_q;
    logic            full, do_push, do_pop;

    assign full    = (cnt_q == FULL_C);
    assign empty_o = (cnt_q == '0);
    assign do_push = push_i && !full;
    assign do_pop  = pop_i && !empty_o;
    assign frame_o = mem[rd_q];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_q] <= frame_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wr_q <= (wr_q == LAST_A) ? '0 : wr_q + AW'(1);
            if (do_pop)  rd_q <= (rd_q == LAST_A) ? '0 : rd_q + AW'(1);
            cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
        end
    end

    // R8
    fifo_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= FULL_C);

    // R8
    full_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (push_i && full && !pop_i) |=> $stable(cnt_q));

endmodule

// File: rtl/aes_mr_serial.sv
module aes_mr_serial
    import aes_mr_pkg::*;
#(
    parameter int SLOT_BITS = 32
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   tick_i,
    input  logic   empty_i,
    input  frame_t head_i,
    output logic   pop_o,
    output logic   bclk_o,
    output logic   wclk_o,
    output logic   sdata_o,
    output logic   underrun_o
);

    localparam int PW = $clog2(2 * SLOT_BITS);
    localparam int KW = $clog2(SLOT_BITS);
    localparam logic [PW-1:0] LAST_P = PW'(2 * SLOT_BITS - 1);

    logic          bclk_q, run_q, phase_q, urun_q;
    logic [PW-1:0] pos_q;
    sample_t       left_q, right_q, hold_q;
    logic          fall, load;

    assign fall  = tick_i && bclk_q;
    assign load  = fall && (run_q ? (pos_q == LAST_P) : !empty_i);
    assign pop_o = load && !phase_q && !empty_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            bclk_q  <= 1'b1;
            run_q   <= 1'b0;
            phase_q <= 1'b0;
            urun_q  <= 1'b0;
            pos_q   <= '0;
            left_q  <= '0;
            right_q <= '0;
            hold_q  <= '0;
        end else begin
            if (tick_i) bclk_q <= !bclk_q;
            if (fall && run_q) pos_q <= (pos_q == LAST_P) ? '0 : pos_q + PW'(1);
            if (load) begin
                run_q <= 1'b1;
                if (phase_q) begin
                    left_q  <= hold_q;
                    right_q <= hold_q;
                    phase_q <= 1'b0;
                end else if (!empty_i) begin
                    if (head_i.mono) begin
                        left_q  <= head_i.a;
                        right_q <= head_i.a;
                        hold_q  <= head_i.b;
                        phase_q <= 1'b1;
                    end else begin
                        left_q  <= head_i.a;
                        right_q <= head_i.b;
                    end
                end else begin
                    urun_q <= 1'b1;
                end
            end
        end
    end

    assign bclk_o     = bclk_q;
    assign wclk_o     = run_q ? pos_q[PW-1] : 1'b1;
    assign sdata_o    = run_q && slot_bit(pos_q[PW-1] ? right_q : left_q, int'(pos_q[KW-1:0]));
    assign underrun_o = urun_q;

    // R2
    wclk_edge_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(wclk_o) |-> $fell(bclk_o));

    // R2
    sdata_edge_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sdata_o) |-> $fell(bclk_o));

    // R9
    underrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        urun_q |=> urun_q);

    // R6
    mono_first_half_chk: assert property (@(posedge clk) disable iff (rst)
        phase_q |-> (left_q == right_q));

endmodule

// File: rtl/aes_mono_router.sv
module aes_mono_router
    import aes_mr_pkg::*;
#(
    parameter int SLOT_BITS  = 32,
    parameter int FIFO_DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mono_mode_i,
    input  logic             sf_valid_i,
    input  logic             sf_is_b_i,
    input  logic             sf_frame_start_i,
    input  logic [SMP_W-1:0] sf_sample_i,
    input  logic             half_tick_i,
    output logic             bclk_o,
    output logic             wclk_o,
    output logic             sdata_o,
    output logic             underrun_o
);

    logic   push, pop, empty;
    frame_t in_frame, head;

    aes_mr_ingest u_ingest (
        .clk      (clk),
        .rst      (rst),
        .mode_i   (mono_mode_i),
        .valid_i  (sf_valid_i),
        .is_b_i   (sf_is_b_i),
        .fstart_i (sf_frame_start_i),
        .sample_i (sf_sample_i),
        .push_o   (push),
        .frame_o  (in_frame)
    );

    aes_mr_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .push_i  (push),
        .frame_i (in_frame),
        .pop_i   (pop),
        .empty_o (empty),
        .frame_o (head)
    );

    aes_mr_serial #(.SLOT_BITS(SLOT_BITS)) u_serial (
        .clk        (clk),
        .rst        (rst),
        .tick_i     (half_tick_i),
        .empty_i    (empty),
        .head_i     (head),
        .pop_o      (pop),
        .bclk_o     (bclk_o),
        .wclk_o     (wclk_o),
        .sdata_o    (sdata_o),
        .underrun_o (underrun_o)
    );

endmodule

// File: tb/aes_mono_router_bench.sv
module aes_mono_router_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mono = 1'b0;
    logic        valid = 1'b0;
    logic        is_b = 1'b0;
    logic        fstart = 1'b0;
    logic [23:0] smp = '0;
    logic        tick = 1'b0;
    logic        bclk, wclk, sdata, urun;

    int checks = 0;
    int fails  = 0;
    bit tick_en = 1'b0;
    bit gap_en  = 1'b0;

    logic [47:0] exp_q[$];
    string       tag_q[$];
    logic [47:0] last_pair;
    int          pairs_done;

    always #2 clk = !clk;

    aes_mono_router u_aes_mono_router (
        .clk(clk), .rst(rst), .mono_mode_i(mono), .sf_valid_i(valid),
        .sf_is_b_i(is_b), .sf_frame_start_i(fstart), .sf_sample_i(smp),
        .half_tick_i(tick), .bclk_o(bclk), .wclk_o(wclk), .sdata_o(sdata),
        .underrun_o(urun)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [47:0] pair_of(input logic [23:0] l, input logic [23:0] r);
        return {l, r};
    endfunction

    // Serial decoder and bit-clock monitor, sampled on the falling clock edge.
    logic        p_bclk, p_w, p_sd, sw;
    int          cnt;
    bit          first_slot;
    logic [23:0] sh, lw;

    task automatic got_pair(input logic [47:0] p);
        logic [47:0] e;
        string       t;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
        end else begin
            e = last_pair;
            t = "R9";
        end
        chk(p == e, t, 64'(p), 64'(e));
        last_pair = e;
        pairs_done++;
    endtask

    initial begin
        void'($urandom(32'd4242));
        forever begin
            @(negedge clk);
            if (rst) begin
                p_bclk = 1'b1; p_w = 1'b1; p_sd = 1'b0; sw = 1'b1;
                cnt = 0; first_slot = 1'b1; sh = '0; lw = '0; last_pair = '0;
            end else begin
                // R2: bit clock inverts exactly on ticked edges
                if ((bclk != p_bclk) != tick)
                    chk(1'b0, "R2", 64'(bclk), 64'(p_bclk ^ tick));
                // R2: word clock and data move only with a falling bit clock
                if ((wclk != p_w || sdata != p_sd) && !(p_bclk && !bclk))
                    chk(1'b0, "R2", 64'({wclk, sdata}), 64'({p_w, p_sd}));
                if (!p_bclk && bclk) begin
                    if (wclk != sw) begin
                        if (!first_slot) chk(cnt == 31, "R3", 64'(cnt), 64'd31);
                        first_slot = 1'b0;
                        cnt = 0;
                        sw = wclk;
                    end else begin
                        cnt++;
                    end
                    if (cnt >= 1 && cnt <= 24) sh = {sh[22:0], sdata};
                    else if (sdata) chk(1'b0, "R3", 64'(sdata), 64'd0);
                    if (cnt == 24) begin
                        if (!wclk) lw = sh;
                        else got_pair(pair_of(lw, sh));
                    end
                end
                p_bclk = bclk; p_w = wclk; p_sd = sdata;
            end
            tick = !rst && tick_en && (!gap_en || ($urandom_range(0, 3) != 0));
        end
    end

    task automatic send_frame(input logic [23:0] a, input logic [23:0] b,
                              input bit m_a, input bit m_b, input bit keep, input string tag);
        @(negedge clk);
        valid = 1'b1; is_b = 1'b0; fstart = 1'b1; smp = a; mono = m_a;
        @(negedge clk);
        is_b = 1'b1; fstart = 1'b0; smp = b; mono = m_b;
        @(negedge clk);
        valid = 1'b0; is_b = 1'b0;
        if (keep) begin
            if (m_a) begin
                exp_q.push_back(pair_of(a, a)); tag_q.push_back(tag);
                exp_q.push_back(pair_of(b, b)); tag_q.push_back(tag);
            end else begin
                exp_q.push_back(pair_of(a, b)); tag_q.push_back(tag);
            end
        end
    endtask

    task automatic stray(input bit as_b);
        @(negedge clk);
        valid = 1'b1; is_b = as_b; fstart = 1'b0; smp = 24'($urandom);
        mono = 1'($urandom);
        @(negedge clk);
        valid = 1'b0; is_b = 1'b0;
    endtask

    task automatic throttle();
        while (exp_q.size() > 1) @(negedge clk);
    endtask

    task automatic do_reset();
        exp_q.delete(); tag_q.delete();
        tick_en = 1'b0;
        @(posedge clk); #1 rst = 1'b1;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    task automatic wait_pairs(input int n);
        int target;
        target = pairs_done + n;
        while (pairs_done < target) @(negedge clk);
    endtask

    initial begin
        pairs_done = 0;
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog", 64'd0, 64'd1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [23:0] ra, rb;
        bit          ma, mb;
        void'($urandom(32'd777));
        do_reset();
        @(negedge clk);
        chk(bclk == 1'b1, "R1", 64'(bclk), 64'd1);
        chk(wclk == 1'b1, "R1", 64'(wclk), 64'd1);
        chk(sdata == 1'b0, "R1", 64'(sdata), 64'd0);
        chk(urun == 1'b0, "R1", 64'(urun), 64'd0);
        tick_en = 1'b1;
        repeat (40) @(negedge clk);
        chk(wclk == 1'b1 && sdata == 1'b0, "R1", 64'({wclk, sdata}), 64'b10);
        chk(urun == 1'b0, "R1", 64'(urun), 64'd0);

        // Directed routing cases
        send_frame(24'hABCDEF, 24'h123456, 1'b0, 1'b0, 1'b1, "R10"); throttle();
        send_frame(24'h800001, 24'h7FFFFE, 1'b1, 1'b1, 1'b1, "R6");  throttle();
        send_frame(24'hFFFFFF, 24'h000000, 1'b0, 1'b0, 1'b1, "R5");  throttle();
        send_frame(24'h5A5A5A, 24'hA5A5A5, 1'b0, 1'b1, 1'b1, "R7");  throttle();
        send_frame(24'h0F0F0F, 24'hF0F0F0, 1'b1, 1'b0, 1'b1, "R7");  throttle();
        stray(1'b1); stray(1'b0); stray(1'b1);
        send_frame(24'h135795, 24'h24680A, 1'b0, 1'b0, 1'b1, "R4");  throttle();

        // Random mix with bit-clock gaps
        gap_en = 1'b1;
        for (int i = 0; i < 80; i++) begin
            if ($urandom_range(0, 7) == 0) stray(1'($urandom));
            ra = 24'($urandom); rb = 24'($urandom);
            ma = 1'($urandom);
            mb = ($urandom_range(0, 3) == 0) ? !ma : ma;
            send_frame(ra, rb, ma, mb, 1'b1, ma ? "R6" : "R5");
            throttle();
        end
        while (exp_q.size() > 0) @(negedge clk);
        chk(urun == 1'b0, "R9", 64'(urun), 64'd0);

        // Starvation: previous pair repeats, flag sticks
        wait_pairs(3);
        chk(urun == 1'b1, "R9", 64'(urun), 64'd1);
        send_frame(24'h3C3C3C, 24'hC3C3C3, 1'b0, 1'b0, 1'b1, "R5");
        while (exp_q.size() > 0) @(negedge clk);
        chk(urun == 1'b1, "R9", 64'(urun), 64'd1);

        // Overflow with the bit clock stopped
        gap_en = 1'b0;
        do_reset();
        send_frame(24'h111111, 24'h222222, 1'b0, 1'b0, 1'b1, "R8");
        send_frame(24'h333333, 24'h444444, 1'b1, 1'b1, 1'b1, "R8");
        send_frame(24'h555555, 24'h666666, 1'b0, 1'b0, 1'b0, "R8");
        repeat (5) @(negedge clk);
        chk(wclk == 1'b1, "R1", 64'(wclk), 64'd1);
        tick_en = 1'b1;
        while (exp_q.size() > 0) @(negedge clk);
        chk(urun == 1'b0, "R8", 64'(urun), 64'd0);
        wait_pairs(1);
        chk(last_pair == pair_of(24'h444444, 24'h444444), "R8", 64'(last_pair), 64'(pair_of(24'h444444, 24'h444444)));
        chk(urun == 1'b1, "R9", 64'(urun), 64'd1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule